// File: doc/BRIEF.md
# Layered Weight Record Store

This block holds one record per network node and hands groups of those records to a compute datapath. A record is a threshold word followed by `NODE_IN` weight words. Records arrive on a valid/ready write stream. Each accepted record goes to the next free RAM location, so the nodes of a layer land side by side. Record word 0 sits in the least significant `WORD_W` bits and holds the threshold. Word `i+1` holds weight `i`.

A read request gives a layer, a starting node, a group size `par` and the layer's highest valid node index. The block first works out how many nodes the request covers. It then reads that many consecutive records from RAM, starting at `layer * MAX_WIDTH + node`. Each returned record is split in two. The threshold goes into one shift register and the weights go into a second. A done flag rises once the last record has been shifted in, and both registers hold their contents until the next request is accepted.

Write stream rules: a record transfers on a rising clock edge where `wr_valid` and `wr_ready` are both high. The writer may hold or change `wr_record` freely while `wr_valid` is low. Once the RAM holds `MAX_WIDTH * MAX_LAYERS` records, `wr_ready` stays low until reset. The read side uses plain control pins: `rd_req` is looked at only while `rd_busy` is low.

Top module: `layer_weight_store`

## Requirements
- R1: While reset is applied and just after it is released, `wr_ready` is 1 and `rd_busy`, `rd_done`, `thr_out` and `wgt_out` are all 0.
- R2: Each record accepted on the write stream is stored at an address equal to the number of records accepted before it. A record offered while `wr_valid` is low is not stored.
- R3: After `MAX_WIDTH * MAX_LAYERS` records have been accepted, `wr_ready` is 0 and stays 0. Records offered after that point leave the stored contents unchanged.
- R4: A request reads records starting at address `rd_layer * MAX_WIDTH + rd_node`, one address higher for each further node.
- R5: The number of records read is k = min(`rd_par`, last − `rd_node` + 1). Here last = min(`rd_max_node`, `MAX_WIDTH` − 1). k is 0 when `rd_node` > last or `rd_par` = 0.
- R6: Slot j of `thr_out` is bits [j·WORD_W +: WORD_W]. Slot j of `wgt_out` holds weight w at bits [(j·NODE_IN+w)·WORD_W +: WORD_W]. Each returned record moves both registers down by one slot and enters at the top slot (`MAX_WIDTH` − 1). After k reads, node `rd_node`+i therefore sits in slot `MAX_WIDTH` − k + i.
- R7: Accepting a request clears both registers, so slots that the request does not fill read as zero.
- R8: `rd_done` becomes 1 on the (k+1)-th rising edge after the accepting edge; when k = 0 that is the first edge. It stays 1 until the next request is accepted and is 0 right after that accepting edge.
- R9: A request raised while `rd_busy` is 1 has no effect on the records read, on the register contents or on the completion timing.
- R10: `rd_busy` is 1 from the accepting edge until the edge that raises `rd_done`, and 0 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write stream: record offered |
| wr_ready | output | 1 | Write stream: room for a record |
| wr_record | input | (NODE_IN+1)*WORD_W | Record: threshold in word 0, weights above it |
| rd_req | input | 1 | Read request, taken when idle |
| rd_layer | input | LAYER_W | Layer index of the request |
| rd_node | input | NODE_W | First node of the request |
| rd_par | input | PAR_W | Group size (nodes per request) |
| rd_max_node | input | NODE_W | Highest valid node index of the layer |
| rd_busy | output | 1 | Request in progress |
| rd_done | output | 1 | Registers hold the result of the last request |
| thr_out | output | MAX_WIDTH*WORD_W | Threshold shift register |
| wgt_out | output | MAX_WIDTH*NODE_IN*WORD_W | Weight shift register |

## Verification
The bench goes after the cases that shorten a group. These are a maximum node index below the end of the group, a maximum node index above the layer width, a start past the last node, and a zero group size. A design that miscounts reads in these cases either pulls records from the next layer, or signals done on the wrong edge and leaves nodes in the wrong slots. Unfilled slots are checked for zeros, which exposes a missing clear. Two stimulus patterns target write-side mistakes: a data word held during a `wr_valid` gap, and a burst offered after the RAM is full. A design that stores either of these, or keeps its write counter moving, returns corrupted records on later reads. Another request is raised while a read is running; a design that restarts on it returns the wrong layer and finishes late.

// File: rtl/lws_pkg.sv
package lws_pkg;

  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_FETCH = 1'b1
  } seq_state_e;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/lws_ram.sv
module lws_ram #(
  parameter int DEPTH = 96,
  parameter int DATA_W = 600,
  parameter int RA_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [RA_W-1:0]   raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/lws_wr_ctrl.sv
module lws_wr_ctrl #(
  parameter int DEPTH = 96,
  parameter int ADDR_W = 7,
  parameter int RA_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  output logic            we,
  output logic [RA_W-1:0] waddr
);

  logic [ADDR_W-1:0] wcnt_q;

  assign wr_ready = (int'(wcnt_q) != DEPTH);
  assign we       = wr_valid && wr_ready;
  assign waddr    = wcnt_q[RA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else if (we) wcnt_q <= wcnt_q + 1'b1;
  end

  AST_WCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wcnt_q) <= DEPTH); // R3
  AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> !wr_ready); // R3

endmodule

// File: rtl/lws_rd_seq.sv
module lws_rd_seq
  import lws_pkg::*;
#(
  parameter int MAX_WIDTH = 24,
  parameter int MAX_LAYERS = 4,
  parameter int LAYER_W = 2,
  parameter int NODE_W = 5,
  parameter int PAR_W = 5,
  parameter int RA_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [LAYER_W-1:0] layer,
  input  logic [NODE_W-1:0]  node,
  input  logic [PAR_W-1:0]   par,
  input  logic [NODE_W-1:0]  max_node,
  output logic               ram_re,
  output logic [RA_W-1:0]    ram_raddr,
  output logic               shift_en,
  output logic               clr,
  output logic               busy,
  output logic               done
);

  seq_state_e        st_q;
  logic [RA_W-1:0]   addr_q;
  logic [PAR_W-1:0]  left_q;
  logic              pend_q;
  logic              done_q;
  logic [RA_W-1:0]   start_addr;
  logic [PAR_W-1:0]  count;
  logic              accept;

  always_comb begin
    int last_n;
    int avail;
    last_n = min_int(int'(max_node), MAX_WIDTH - 1);
    avail  = (int'(node) > last_n) ? 0 : (last_n - int'(node) + 1);
    count  = PAR_W'(min_int(int'(par), avail));
    start_addr = RA_W'(int'(layer) * MAX_WIDTH + int'(node));
  end

  assign accept    = (st_q == SQ_IDLE) && req;
  assign ram_re    = (st_q == SQ_FETCH) && (left_q != '0);
  assign ram_raddr = addr_q;
  assign shift_en  = pend_q;
  assign clr       = accept;
  assign busy      = (st_q == SQ_FETCH);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      left_q <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (req) begin
            st_q   <= SQ_FETCH;
            addr_q <= start_addr;
            left_q <= count;
            pend_q <= 1'b0;
            done_q <= 1'b0;
          end
        end
        SQ_FETCH: begin
          pend_q <= ram_re;
          if (ram_re) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
          end else begin
            st_q   <= SQ_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_ACCEPT_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done_q); // R8
  AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FETCH) |=> (left_q <= $past(left_q))); // R9
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> (int'(ram_raddr) < MAX_WIDTH * MAX_LAYERS)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R10

endmodule

// File: rtl/lws_shift.sv
module lws_shift #(
  parameter int WORD_W = 24,
  parameter int NODE_IN = 24,
  parameter int SLOTS = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              shift_en,
  input  logic [(NODE_IN+1)*WORD_W-1:0]     rec_in,
  output logic [SLOTS*WORD_W-1:0]           thr_q,
  output logic [SLOTS*NODE_IN*WORD_W-1:0]   wgt_q
);

  localparam int REC_W   = (NODE_IN + 1) * WORD_W;
  localparam int BLK_W   = NODE_IN * WORD_W;
  localparam int THR_TOT = SLOTS * WORD_W;
  localparam int WGT_TOT = SLOTS * BLK_W;

  generate
    if (SLOTS == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          thr_q <= '0;
          wgt_q <= '0;
        end else if (clr) begin
          thr_q <= '0;
          wgt_q <= '0;
        end else if (shift_en) begin
          thr_q <= rec_in[WORD_W-1:0];
          wgt_q <= rec_in[REC_W-1:WORD_W];
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          thr_q <= '0;
          wgt_q <= '0;
        end else if (clr) begin
          thr_q <= '0;
          wgt_q <= '0;
        end else if (shift_en) begin
          thr_q <= {rec_in[WORD_W-1:0], thr_q[THR_TOT-1:WORD_W]};
          wgt_q <= {rec_in[REC_W-1:WORD_W], wgt_q[WGT_TOT-1:BLK_W]};
        end
      end
    end
  endgenerate

endmodule

// File: rtl/layer_weight_store.sv
module layer_weight_store #(
  parameter int WORD_W = 24,
  parameter int NODE_IN = 24,
  parameter int MAX_WIDTH = 24,
  parameter int MAX_LAYERS = 4,
  localparam int REC_W = (NODE_IN + 1) * WORD_W,
  localparam int LAYER_W = (MAX_LAYERS > 1) ? $clog2(MAX_LAYERS) : 1,
  localparam int NODE_W = (MAX_WIDTH > 1) ? $clog2(MAX_WIDTH) : 1,
  localparam int PAR_W = $clog2(MAX_WIDTH + 1),
  localparam int THR_TOT = MAX_WIDTH * WORD_W,
  localparam int WGT_TOT = MAX_WIDTH * NODE_IN * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [REC_W-1:0]   wr_record,
  input  logic               rd_req,
  input  logic [LAYER_W-1:0] rd_layer,
  input  logic [NODE_W-1:0]  rd_node,
  input  logic [PAR_W-1:0]   rd_par,
  input  logic [NODE_W-1:0]  rd_max_node,
  output logic               rd_busy,
  output logic               rd_done,
  output logic [THR_TOT-1:0] thr_out,
  output logic [WGT_TOT-1:0] wgt_out
);

  localparam int DEPTH  = MAX_WIDTH * MAX_LAYERS;
  localparam int ADDR_W = $clog2(DEPTH + 1);
  localparam int RA_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             we;
  logic [RA_W-1:0]  waddr;
  logic             ram_re;
  logic [RA_W-1:0]  ram_raddr;
  logic [REC_W-1:0] ram_q;
  logic             shift_en;
  logic             clr;

  lws_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RA_W(RA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .we(we), .waddr(waddr)
  );

  lws_ram #(.DEPTH(DEPTH), .DATA_W(REC_W), .RA_W(RA_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_record),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );

  lws_rd_seq #(
    .MAX_WIDTH(MAX_WIDTH), .MAX_LAYERS(MAX_LAYERS), .LAYER_W(LAYER_W),
    .NODE_W(NODE_W), .PAR_W(PAR_W), .RA_W(RA_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .layer(rd_layer), .node(rd_node),
    .par(rd_par), .max_node(rd_max_node), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .shift_en(shift_en), .clr(clr), .busy(rd_busy), .done(rd_done)
  );

  lws_shift #(.WORD_W(WORD_W), .NODE_IN(NODE_IN), .SLOTS(MAX_WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en), .rec_in(ram_q),
    .thr_q(thr_out), .wgt_q(wgt_out)
  );

  AST_SHIFT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> $past(ram_re)); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !shift_en); // R8
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !we); // R3

endmodule

// File: tb/tb_layer_weight_store.sv
module tb_layer_weight_store;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 8;
  localparam int NODE_IN = 3;
  localparam int MAX_WIDTH = 3;
  localparam int MAX_LAYERS = 4;
  localparam int REC_W = (NODE_IN + 1) * WORD_W;
  localparam int THR_TOT = MAX_WIDTH * WORD_W;
  localparam int WGT_TOT = MAX_WIDTH * NODE_IN * WORD_W;
  localparam int DEPTH = MAX_WIDTH * MAX_LAYERS;

  // vector: {layer[1:0], node[1:0], par[1:0], max_node[1:0], expected_k[1:0]}
  localparam int NVEC = 11;
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 2'd3, 2'd2, 2'd3},
    {2'd1, 2'd0, 2'd3, 2'd2, 2'd3},
    {2'd2, 2'd1, 2'd2, 2'd2, 2'd2},
    {2'd3, 2'd1, 2'd3, 2'd2, 2'd2},
    {2'd1, 2'd2, 2'd1, 2'd2, 2'd1},
    {2'd2, 2'd0, 2'd3, 2'd1, 2'd2},
    {2'd0, 2'd2, 2'd3, 2'd1, 2'd0},
    {2'd3, 2'd0, 2'd0, 2'd2, 2'd0},
    {2'd2, 2'd0, 2'd3, 2'd3, 2'd3},
    {2'd3, 2'd3, 2'd2, 2'd3, 2'd0},
    {2'd0, 2'd1, 2'd1, 2'd3, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [REC_W-1:0] wr_record = '0;
  logic rd_req = 1'b0;
  logic [1:0] rd_layer = '0;
  logic [1:0] rd_node = '0;
  logic [1:0] rd_par = '0;
  logic [1:0] rd_max_node = '0;
  logic rd_busy;
  logic rd_done;
  logic [THR_TOT-1:0] thr_out;
  logic [WGT_TOT-1:0] wgt_out;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  layer_weight_store #(
    .WORD_W(WORD_W), .NODE_IN(NODE_IN), .MAX_WIDTH(MAX_WIDTH), .MAX_LAYERS(MAX_LAYERS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_record(wr_record), .rd_req(rd_req), .rd_layer(rd_layer), .rd_node(rd_node),
    .rd_par(rd_par), .rd_max_node(rd_max_node), .rd_busy(rd_busy), .rd_done(rd_done),
    .thr_out(thr_out), .wgt_out(wgt_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] word_of(input int n, input int w);
    return WORD_W'(n * 16 + w + 1);
  endfunction

  function automatic logic [REC_W-1:0] rec_of(input int n);
    logic [REC_W-1:0] r;
    r = '0;
    for (int w = 0; w <= NODE_IN; w++) r[w*WORD_W +: WORD_W] = word_of(n, w);
    return r;
  endfunction

  function automatic logic [THR_TOT-1:0] exp_thr(input int start, input int k);
    logic [THR_TOT-1:0] v;
    v = '0;
    for (int i = 0; i < k; i++) v[(MAX_WIDTH-k+i)*WORD_W +: WORD_W] = word_of(start + i, 0);
    return v;
  endfunction

  function automatic logic [WGT_TOT-1:0] exp_wgt(input int start, input int k);
    logic [WGT_TOT-1:0] v;
    v = '0;
    for (int i = 0; i < k; i++)
      for (int w = 0; w < NODE_IN; w++)
        v[((MAX_WIDTH-k+i)*NODE_IN+w)*WORD_W +: WORD_W] = word_of(start + i, w + 1);
    return v;
  endfunction

  task automatic run_read(input int lay, input int nd, input int pr, input int mx,
                          input int ek, input bit poke, input string pfx);
    int n;
    int start;
    logic [THR_TOT-1:0] et;
    logic [WGT_TOT-1:0] ew;
    start = lay * MAX_WIDTH + nd;
    et = exp_thr(start, ek);
    ew = exp_wgt(start, ek);
    @(negedge clk);
    rd_layer = 2'(lay); rd_node = 2'(nd); rd_par = 2'(pr); rd_max_node = 2'(mx);
    rd_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (poke) begin
      rd_layer = 2'(lay ^ 1); rd_node = 2'd0; rd_par = 2'd1; rd_max_node = 2'd2;
    end else begin
      rd_req = 1'b0;
    end
    chk(rd_busy == 1'b1, {pfx, "R10 busy after accept"}, 128'(rd_busy), 128'(1));
    chk(rd_done == 1'b0, {pfx, "R8 done cleared on accept"}, 128'(rd_done), 128'(0));
    n = 0;
    while (!rd_done && n < 20) begin
      @(negedge clk);
      n++;
      if (n == 1) rd_req = 1'b0;
    end
    chk(n == ek + 1, {pfx, "R5 R8 done edge after accept"}, 128'(n), 128'(ek + 1));
    chk(rd_busy == 1'b0, {pfx, "R10 idle with done"}, 128'(rd_busy), 128'(0));
    chk(thr_out == et, {pfx, "R4 R6 R7 thresholds"}, 128'(thr_out), 128'(et));
    chk(wgt_out == ew, {pfx, "R4 R6 R7 weights"}, 128'(wgt_out), 128'(ew));
    @(negedge clk);
    @(negedge clk);
    chk(rd_done == 1'b1 && thr_out == et, {pfx, "R8 done and data hold"},
        128'(thr_out), 128'(et));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_ready == 1'b1 && rd_busy == 1'b0 && rd_done == 1'b0, "R1 in reset",
        128'({wr_ready, rd_busy, rd_done}), 128'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    chk(thr_out == '0 && wgt_out == '0, "R1 registers zero",
        128'(thr_out), 128'(0));
    chk(wr_ready == 1'b1 && rd_busy == 1'b0 && rd_done == 1'b0, "R1 after release",
        128'({wr_ready, rd_busy, rd_done}), 128'(3'b100));

    // R2: fill with gaps; gap cycles carry a garbage record with valid low
    for (int n = 0; n < DEPTH; n++) begin
      if (n % 3 == 1) begin
        wr_valid = 1'b0;
        wr_record = 32'hDEAD_BEEF;
        @(negedge clk);
      end
      if (n == DEPTH - 1)
        chk(wr_ready == 1'b1, "R3 ready before last slot", 128'(wr_ready), 128'(1));
      wr_valid = 1'b1;
      wr_record = rec_of(n);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    chk(wr_ready == 1'b0, "R3 not ready when full", 128'(wr_ready), 128'(0));
    // R3: offers after full must be dropped
    wr_valid = 1'b1;
    wr_record = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    chk(wr_ready == 1'b0, "R3 stays not ready", 128'(wr_ready), 128'(0));

    for (int v = 0; v < NVEC; v++) begin
      run_read(int'(VEC[v][9:8]), int'(VEC[v][7:6]), int'(VEC[v][5:4]),
               int'(VEC[v][3:2]), int'(VEC[v][1:0]), 1'b0, "");
    end

    // R9: a second request held high during a running read is ignored
    run_read(1, 1, 2, 2, 2, 1'b1, "R9 ");
    // R3: last slot still holds its original record after the dropped offers
    run_read(3, 2, 1, 2, 1, 1'b0, "R3 ");
    // R2: first slot intact
    run_read(0, 0, 1, 2, 1, 1'b0, "R2 ");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule